// File: doc/BRIEF.md
# Ethernet Controller Bring-Up Sequencer

This block runs the one-time start-up program for an SPI-attached Ethernet controller. It comes out of reset and drives a word access engine, one register access at a time, over a request/response interface. It waits for the controller to report that boot has finished by reading the byte-order test register and checking for a known pattern. It then patches the hardware configuration word and writes one MAC register through the controller's indirect data/command register pair. After that it waits for the indirect command to leave the busy state and, as the last step, turns on the transmitter.

Each request is presented with its address, direction and write data, and held until the engine accepts it. The sequencer then waits for exactly one response, which carries read data and an error flag, before it issues the next access. The run ends in one of two sticky states: `init_done` after a clean final write, or `init_error` when an access fails or a bounded poll runs out. Both states hold until reset.

Top module: `netctl_bringup`

## Requirements
- R1: While reset is high, and in the first cycle after it, `req_valid`, `init_done` and `init_error` are all 0.
- R2: The first access after reset reads address 0x064. That read is repeated until the returned word equals 0x87654321. A match moves the sequence on to the configuration step.
- R3: When BOOT_TRIES consecutive boot reads all miss the pattern, `init_error` rises and no further request is made.
- R4: An error response to a boot read raises `init_error` at once and ends polling.
- R5: The sequencer reads address 0x074 and writes the returned word back to 0x074 with bit 20 set, bit 21 cleared and all other bits unchanged.
- R6: The sequencer then writes 0x0014000C (bits 20, 18, 3, 2) to address 0x0A8. It follows with a write of 0x80000001 (bit 31 as the start flag, MAC register index 1 in the low bits) to address 0x0A4.
- R7: After the command write, the sequencer reads 0x064 once and ignores the result. It then reads 0x0A4 repeatedly until bit 31 of the returned word is 0.
- R8: When BUSY_TRIES consecutive reads of 0x0A4 all return bit 31 set, `init_error` rises and no further request is made.
- R9: The last access writes 0x00000006 to address 0x070. `init_done` rises only after the error-free response to that write.
- R10: An error response to any access after boot wait raises `init_error` and no further request is made.
- R11: Once `req_valid` is high, it stays high with `req_addr`, `req_write` and `req_wdata` unchanged until a cycle in which `req_ready` is high.
- R12: `init_done` and `init_error` are never high together. Once set, each stays set and `req_valid` stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | output | 1 | Access request present |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Controller register address |
| req_wdata | output | 32 | Write data |
| req_ready | input | 1 | Engine accepts the request this cycle |
| resp_valid | input | 1 | Engine returns the result of the accepted access |
| resp_err | input | 1 | The access failed |
| resp_rdata | input | 32 | Read data |
| init_done | output | 1 | Sequence completed without error |
| init_error | output | 1 | Sequence aborted |

## Verification
The bench builds the block with BOOT_TRIES set to 5 and BUSY_TRIES set to 4. With these small limits, running out of boot retries and timing out on the busy poll take only a handful of accesses. That puts the exact limit (a match on the last allowed try) and the case one try past it within reach of both directed and random cases. The engine model adds random accept and response delays, so the request-hold rule is exercised over many waits. Error responses are injected at chosen and random positions in the access stream, which covers aborts from every step.

// File: rtl/netctl_bringup_pkg.sv
package netctl_bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BOOT,
    ST_CFG_RD,
    ST_CFG_WR,
    ST_MAC_DATA,
    ST_MAC_CMD,
    ST_FLUSH_RD,
    ST_BUSY_RD,
    ST_TX_EN,
    ST_DONE,
    ST_FAIL
  } step_e;

  localparam logic [31:0] REG_BOOT_TEST = 32'h0000_0064;
  localparam logic [31:0] REG_HW_CONFIG = 32'h0000_0074;
  localparam logic [31:0] REG_MAC_DATA  = 32'h0000_00A8;
  localparam logic [31:0] REG_MAC_CMD   = 32'h0000_00A4;
  localparam logic [31:0] REG_TX_CTRL   = 32'h0000_0070;

  localparam logic [31:0] BOOT_PATTERN  = 32'h8765_4321;
  localparam int          CFG_SET_BIT   = 20;
  localparam int          CFG_CLR_BIT   = 21;
  localparam int          CMD_BUSY_BIT  = 31;
  localparam logic [31:0] MAC_CTRL_IDX  = 32'd1;
  localparam logic [31:0] MAC_CTRL_VAL  = (32'd1 << 20) | (32'd1 << 18) | (32'd1 << 3) | (32'd1 << 2);
  localparam logic [31:0] TX_CTRL_VAL   = (32'd1 << 2) | (32'd1 << 1);

endpackage

// File: rtl/netctl_try_counter.sv
module netctl_try_counter #(
  parameter int unsigned TRIES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic last
);
  localparam int CW = $clog2(TRIES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= CW'(TRIES);
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CW'(1));

  // R3 / R8: a retry is only spent while more than one remains
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt_q > CW'(1)));

endmodule

// File: rtl/netctl_step_table.sv
module netctl_step_table
  import netctl_bringup_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  step_e             step_i,
  input  logic [31:0]       cfg_raw,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic [31:0]       wdata_o
);
  logic [31:0] addr32;
  logic [31:0] cfg_patched;

  always_comb begin
    cfg_patched = cfg_raw;
    cfg_patched[CFG_SET_BIT] = 1'b1;
    cfg_patched[CFG_CLR_BIT] = 1'b0;
  end

  always_comb begin
    addr32  = REG_BOOT_TEST;
    write_o = 1'b0;
    wdata_o = '0;
    case (step_i)
      ST_CFG_RD:   addr32 = REG_HW_CONFIG;
      ST_CFG_WR:   begin addr32 = REG_HW_CONFIG; write_o = 1'b1; wdata_o = cfg_patched; end
      ST_MAC_DATA: begin addr32 = REG_MAC_DATA;  write_o = 1'b1; wdata_o = MAC_CTRL_VAL; end
      ST_MAC_CMD:  begin addr32 = REG_MAC_CMD;   write_o = 1'b1;
                         wdata_o = (32'd1 << CMD_BUSY_BIT) | MAC_CTRL_IDX; end
      ST_BUSY_RD:  addr32 = REG_MAC_CMD;
      ST_TX_EN:    begin addr32 = REG_TX_CTRL;   write_o = 1'b1; wdata_o = TX_CTRL_VAL; end
      default:     addr32 = REG_BOOT_TEST;
    endcase
  end

  assign addr_o = addr32[ADDR_W-1:0];

endmodule

// File: rtl/netctl_bringup.sv
module netctl_bringup
  import netctl_bringup_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int unsigned BOOT_TRIES = 100000,
  parameter int unsigned BUSY_TRIES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_wdata,
  input  logic              req_ready,
  input  logic              resp_valid,
  input  logic              resp_err,
  input  logic [31:0]       resp_rdata,
  output logic              init_done,
  output logic              init_error
);
  step_e step_q, step_nx;
  logic  wait_q;
  logic  fire;
  logic  boot_load, boot_dec, boot_last;
  logic  busy_load, busy_dec, busy_last;
  logic [ADDR_W-1:0] tbl_addr;
  logic              tbl_write;
  logic [31:0]       tbl_wdata;

  assign fire = (step_q == ST_IDLE) || (wait_q && resp_valid);

  always_comb begin
    step_nx  = step_q;
    boot_dec = 1'b0;
    busy_dec = 1'b0;
    case (step_q)
      ST_IDLE:     step_nx = ST_BOOT;
      ST_BOOT:
        if (resp_err)                       step_nx = ST_FAIL;
        else if (resp_rdata == BOOT_PATTERN) step_nx = ST_CFG_RD;
        else if (boot_last)                 step_nx = ST_FAIL;
        else begin step_nx = ST_BOOT; boot_dec = fire; end
      ST_CFG_RD:   step_nx = resp_err ? ST_FAIL : ST_CFG_WR;
      ST_CFG_WR:   step_nx = resp_err ? ST_FAIL : ST_MAC_DATA;
      ST_MAC_DATA: step_nx = resp_err ? ST_FAIL : ST_MAC_CMD;
      ST_MAC_CMD:  step_nx = resp_err ? ST_FAIL : ST_FLUSH_RD;
      ST_FLUSH_RD: step_nx = resp_err ? ST_FAIL : ST_BUSY_RD;
      ST_BUSY_RD:
        if (resp_err)                     step_nx = ST_FAIL;
        else if (!resp_rdata[CMD_BUSY_BIT]) step_nx = ST_TX_EN;
        else if (busy_last)               step_nx = ST_FAIL;
        else begin step_nx = ST_BUSY_RD; busy_dec = fire; end
      ST_TX_EN:    step_nx = resp_err ? ST_FAIL : ST_DONE;
      default:     step_nx = step_q;
    endcase
  end

  assign boot_load = (step_q == ST_IDLE);
  assign busy_load = fire && (step_q == ST_FLUSH_RD);

  netctl_try_counter #(.TRIES(BOOT_TRIES)) u_boot_cnt (
    .clk(clk), .rst(rst), .load(boot_load), .dec(boot_dec), .last(boot_last)
  );

  netctl_try_counter #(.TRIES(BUSY_TRIES)) u_busy_cnt (
    .clk(clk), .rst(rst), .load(busy_load), .dec(busy_dec), .last(busy_last)
  );

  netctl_step_table #(.ADDR_W(ADDR_W)) u_table (
    .step_i(step_nx), .cfg_raw(resp_rdata),
    .addr_o(tbl_addr), .write_o(tbl_write), .wdata_o(tbl_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q     <= ST_IDLE;
      wait_q     <= 1'b0;
      req_valid  <= 1'b0;
      req_write  <= 1'b0;
      req_addr   <= '0;
      req_wdata  <= '0;
      init_done  <= 1'b0;
      init_error <= 1'b0;
    end else if (req_valid && req_ready) begin
      req_valid <= 1'b0;
      wait_q    <= 1'b1;
    end else if (fire) begin
      wait_q <= 1'b0;
      step_q <= step_nx;
      if (step_nx == ST_DONE)      init_done  <= 1'b1;
      else if (step_nx == ST_FAIL) init_error <= 1'b1;
      else begin
        req_valid <= 1'b1;
        req_write <= tbl_write;
        req_addr  <= tbl_addr;
        req_wdata <= tbl_wdata;
      end
    end
  end

  // R11: request held steady until accepted
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)));

  // R12: outcomes exclusive and sticky
  p_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(init_done && init_error));
  p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (init_done || init_error) |=> (init_done || init_error) && !req_valid);

  // R10: no traffic once the run has ended
  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (init_done || init_error) |-> !req_valid);

  // R5: configuration write-back carries the forced bits
  p_cfg_bits_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == REG_HW_CONFIG[ADDR_W-1:0])
      |-> (req_wdata[CFG_SET_BIT] && !req_wdata[CFG_CLR_BIT]));

  // R9: done follows a clean response to the transmit-enable write
  p_done_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> $past(resp_valid && !resp_err && req_write &&
                               req_addr == REG_TX_CTRL[ADDR_W-1:0]));

endmodule

// File: tb/netctl_bringup_test.sv
module netctl_bringup_test;
  localparam int ADDR_W = 16;
  localparam int BOOT   = 5;
  localparam int BUSY   = 4;
  localparam logic [31:0] PAT = 32'h8765_4321;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic              req_ready  = 1'b0;
  logic              resp_valid = 1'b0;
  logic              resp_err   = 1'b0;
  logic [31:0]       resp_rdata = '0;
  logic              init_done, init_error;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  netctl_bringup #(.ADDR_W(ADDR_W), .BOOT_TRIES(BOOT), .BUSY_TRIES(BUSY)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .init_done(init_done), .init_error(init_error)
  );

  // expected and observed access lists
  logic [15:0] exp_addr [64];
  logic        exp_wr   [64];
  logic [31:0] exp_data [64];
  int          en;
  bit          exp_done, exp_err, stop;
  logic [15:0] act_addr [64];
  logic        act_wr   [64];
  logic [31:0] act_data [64];
  int          an;
  bit          hold_bad;

  int          cur_ok_after, cur_busy, cur_err_at;
  logic [31:0] cur_cfg;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic w, input logic [31:0] d);
    if (stop) return;
    exp_addr[en] = a; exp_wr[en] = w; exp_data[en] = d;
    if (en == cur_err_at) begin exp_err = 1; stop = 1; end
    en++;
  endtask

  function automatic logic [31:0] patch(input logic [31:0] v);
    logic [31:0] r;
    r = v;
    r[20] = 1'b1;
    r[21] = 1'b0;
    return r;
  endfunction

  task automatic build_exp();
    en = 0; exp_done = 0; exp_err = 0; stop = 0;
    for (int k = 0; !stop; k++) begin
      push(16'h064, 1'b0, '0);
      if (stop) break;
      if (k == cur_ok_after) break;
      if (k + 1 == BOOT) begin exp_err = 1; stop = 1; end
    end
    push(16'h074, 1'b0, '0);
    push(16'h074, 1'b1, patch(cur_cfg));
    push(16'h0A8, 1'b1, 32'h0014_000C);
    push(16'h0A4, 1'b1, 32'h8000_0001);
    push(16'h064, 1'b0, '0);
    for (int j = 0; !stop; j++) begin
      push(16'h0A4, 1'b0, '0);
      if (stop) break;
      if (j < cur_busy) begin
        if (j + 1 == BUSY) begin exp_err = 1; stop = 1; end
      end else break;
    end
    push(16'h070, 1'b1, 32'h0000_0006);
    if (!stop) exp_done = 1;
  endtask

  task automatic engine();
    int boot_k = 0, busy_k = 0;
    bit seen_cfg = 0;
    an = 0; hold_bad = 0;
    while (an < 64) begin
      logic [15:0] a;
      logic        w;
      logic [31:0] d, rd;
      bit          e;
      int          t = 0;
      while (!req_valid && !init_done && !init_error && t < 200) begin
        @(negedge clk); t++;
      end
      if (!req_valid) break;
      a = req_addr; w = req_write; d = req_wdata;
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        if (!req_valid || req_addr !== a || req_write !== w || req_wdata !== d) hold_bad = 1;
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      act_addr[an] = a; act_wr[an] = w; act_data[an] = d;
      e = (an == cur_err_at);
      if (!w && a == 16'h064 && !seen_cfg) begin
        rd = (boot_k == cur_ok_after) ? PAT : (PAT ^ ($urandom | 32'd1));
        boot_k++;
      end else if (!w && a == 16'h074) begin
        rd = cur_cfg; seen_cfg = 1;
      end else if (!w && a == 16'h0A4) begin
        rd = $urandom;
        rd[31] = (busy_k < cur_busy);
        busy_k++;
      end else rd = $urandom;
      an++;
      repeat ($urandom_range(0, 2)) @(negedge clk);
      resp_valid = 1'b1; resp_err = e; resp_rdata = rd;
      @(negedge clk);
      resp_valid = 1'b0; resp_err = 1'b0;
    end
  endtask

  function automatic string tag_of(input logic [15:0] a, input logic w);
    if (a == 16'h064) return "R2";
    if (a == 16'h074) return "R5";
    if (a == 16'h0A4 && !w) return "R7";
    if (a == 16'h070) return "R9";
    return "R6";
  endfunction

  task automatic run_case(input string otag, input int ok_after, input int busy_n,
                          input int err_at, input logic [31:0] cfg);
    cur_ok_after = ok_after; cur_busy = busy_n; cur_err_at = err_at; cur_cfg = cfg;
    build_exp();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!req_valid && !init_done && !init_error, "R1", "idle in reset",
        {29'd0, req_valid, init_done, init_error}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!init_done && !init_error, "R1", "idle after reset",
        {30'd0, init_done, init_error}, 32'd0);
    engine();
    chk(an == en, otag, "access count", an, en);
    for (int i = 0; i < an && i < en; i++) begin
      chk(act_addr[i] === exp_addr[i] && act_wr[i] === exp_wr[i],
          tag_of(exp_addr[i], exp_wr[i]), "address/direction",
          {act_wr[i], 15'd0, act_addr[i]}, {exp_wr[i], 15'd0, exp_addr[i]});
      if (exp_wr[i])
        chk(act_data[i] === exp_data[i], tag_of(exp_addr[i], exp_wr[i]), "write data",
            act_data[i], exp_data[i]);
    end
    chk(init_done === exp_done && init_error === exp_err, otag, "outcome",
        {30'd0, init_done, init_error}, {30'd0, exp_done, exp_err});
    chk(!hold_bad, "R11", "request held until accepted", hold_bad, 0);
    repeat (10) @(negedge clk);
    chk(!req_valid && init_done === exp_done && init_error === exp_err && !(init_done && init_error),
        "R12", "terminal state stable",
        {29'd0, req_valid, init_done, init_error}, {30'd0, exp_done, exp_err});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R2: first boot read matches
    run_case("R9", 0, 0, -1, 32'h0020_1234);
    // R2/R7: late match, busy twice
    run_case("R9", 3, 2, -1, 32'hFFFF_FFFF);
    // R2 boundary: match on last allowed try
    run_case("R9", BOOT - 1, 0, -1, 32'h0000_0000);
    // R3: never matches
    run_case("R3", -1, 0, -1, 32'h1);
    // R4: error on a boot read
    run_case("R4", 3, 0, 1, 32'h2);
    // R7 boundary: busy clears on last allowed read
    run_case("R9", 0, BUSY - 1, -1, 32'hA5A5_5A5A);
    // R8: busy never clears
    run_case("R8", 0, BUSY, -1, 32'h3);
    // R10: error on configuration write, and on final write
    run_case("R10", 1, 0, 3, 32'h00300000);
    run_case("R10", 0, 1, 8, 32'h4);
    for (int r = 0; r < 8; r++) begin
      int oa, bn, ea;
      oa = $urandom_range(0, BOOT + 1);
      bn = $urandom_range(0, BUSY + 1);
      ea = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 12)) : -1;
      run_case("R10", oa, bn, ea, $urandom);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule